// File: doc/BRIEF.md
# Extended State Save Sequencer

This block plans the memory image for saving extended processor state. A start pulse carries a 64-byte-aligned base address, the enabled-feature mask, the request mask, a per-component in-use vector, the old state-bitmap word already read from the image header, and a mode: standard, optimized or compacted. The block ANDs the enabled and requested masks. It then walks the selected components in a fixed order and emits one descriptor per accepted handshake. Each descriptor gives the component, the byte address and a flag saying whether the data must really be written.

The control/status word slot and the header words are emitted as descriptors too, with the header values carried on a data field. A one-cycle done pulse follows the last descriptor. A misaligned base produces a one-cycle fault pulse and nothing else. The register data movement and the memory accesses are performed by neighbouring logic that consumes the descriptors.

Top module: `xsave_seq`

## Requirements
- R1: The selected set is the bitwise AND of `feat_en_i` and `feat_req_i`. No descriptor is emitted for a component outside that set.
- R2: A start whose base has any of bits 5..0 set raises `fault_o` for exactly the next cycle. No descriptor and no done pulse follow. Every emitted address is a multiple of 8.
- R3: Descriptors come in this order:
  - component 0
  - the control/status slot
  - component 1
  - components 2, 5, 6 and 7
  - the state header
  - the compaction header (compacted mode only)

  `desc_kind_o` is 0 for a component, 1 for the control/status slot and 2 for a header word.
- R4: In standard and optimized modes (`mode_i` 0 and 1; value 3 acts as standard), the component offsets from base are fixed:

  | Component | Offset |
  |---|---|
  | 0 | 0 |
  | 1 | 160 |
  | 2 | 576 |
  | 5 | 1088 |
  | 6 | 1152 |
  | 7 | 1664 |
- R5: In compacted mode (`mode_i` 2), components 0 and 1 keep offsets 0 and 160. Components 2, 5, 6 and 7 are packed from offset 576 upward. Only selected ones advance the offset, by 256, 64, 512 and 1024 bytes respectively.
- R6: `desc_write_o` is 1 for every component in standard mode. In optimized and compacted modes it equals the component's in-use bit. It is 1 for the control/status slot and for headers.
- R7: The control/status slot (offset 24) is emitted when component 1 is selected, or when component 2 is selected in a non-compacted mode.
- R8: In standard and optimized modes the state header goes to offset 512. Its value is `old_state_i` with each selected bit replaced by that component's in-use bit.
- R9: In compacted mode the state header at offset 512 is selected AND in-use. The compaction header at offset 520 is the selected mask with bit 63 set.
- R10: `desc_valid_o` rises in the cycle after the accepted start. A descriptor is held stable while `desc_ready_i` is low, and one is retired per cycle in which valid and ready are both high.
- R11: `done_o` is high for exactly one cycle, the cycle after the last descriptor is accepted. A start while a descriptor is pending is ignored, as are input changes after the start.
- R12: After reset, `desc_valid_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_i | input | 64 | Image base address |
| feat_en_i | input | 8 | Enabled-feature mask |
| feat_req_i | input | 8 | Request mask |
| in_use_i | input | 8 | Per-component in-use vector |
| mode_i | input | 2 | 0 standard, 1 optimized, 2 compacted |
| old_state_i | input | 64 | State bitmap previously held at base+512 |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Descriptor accepted |
| desc_kind_o | output | 2 | 0 component, 1 control/status, 2 header |
| desc_comp_o | output | 3 | Component index for kind 0 |
| desc_addr_o | output | 64 | Byte address |
| desc_write_o | output | 1 | Data must be written |
| desc_data_o | output | 64 | Header value for kind 2, else 0 |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle alignment fault pulse |

## Verification
Inputs change on the falling edge. The first descriptor is visible in the cycle that follows the start edge. A fault pulse is due exactly one cycle after a misaligned start. The done pulse is due one cycle after the edge that accepts the last descriptor, and it is gone one cycle later. The bench samples every output at the falling edge. It records a descriptor only when it is also driving ready high in that cycle, so each record matches one retiring edge even under stalled ready patterns and an ignored restart.

// File: rtl/xsave_seq_pkg.sv
package xsave_seq_pkg;
  localparam int NSLOT = 9;
  localparam int NEXT  = 4;
  localparam int OFF_W = 12;

  localparam int SL_X87 = 0;
  localparam int SL_CSR = 1;
  localparam int SL_SSE = 2;
  localparam int SL_EXT = 3;
  localparam int SL_HST = 7;
  localparam int SL_HCP = 8;

  localparam logic [1:0] MODE_STD = 2'd0;
  localparam logic [1:0] MODE_OPT = 2'd1;
  localparam logic [1:0] MODE_CMP = 2'd2;

  localparam logic [1:0] KIND_COMP = 2'd0;
  localparam logic [1:0] KIND_CSR  = 2'd1;
  localparam logic [1:0] KIND_HDR  = 2'd2;

  function automatic int ext_bit(int k);
    case (k)
      0: return 2;
      1: return 5;
      2: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic int ext_size(int k);
    case (k)
      0: return 256;
      1: return 64;
      2: return 512;
      default: return 1024;
    endcase
  endfunction

  function automatic int ext_std_off(int k);
    case (k)
      0: return 576;
      1: return 1088;
      2: return 1152;
      default: return 1664;
    endcase
  endfunction

  function automatic logic [2:0] slot_comp(int s);
    if (s == SL_SSE) return 3'd1;
    if (s >= SL_EXT && s < SL_EXT + NEXT) return 3'(ext_bit(s - SL_EXT));
    return 3'd0;
  endfunction

  function automatic logic [1:0] slot_kind(int s);
    if (s == SL_CSR) return KIND_CSR;
    if (s >= SL_HST) return KIND_HDR;
    return KIND_COMP;
  endfunction
endpackage

// File: rtl/xsave_layout.sv
module xsave_layout
  import xsave_seq_pkg::*;
#(
  parameter int FEAT_W = 8
) (
  input  logic [FEAT_W-1:0]            rfbm_i,
  input  logic                         compact_i,
  output logic [NSLOT-1:0][OFF_W-1:0]  off_o,
  output logic [NSLOT-1:0]             act_o
);
  logic [NEXT-1:0][OFF_W-1:0] acc;
  logic unused_bits;

  assign unused_bits = ^rfbm_i[4:3];
  assign acc[0] = OFF_W'(576);

  assign off_o[SL_X87] = OFF_W'(0);
  assign off_o[SL_CSR] = OFF_W'(24);
  assign off_o[SL_SSE] = OFF_W'(160);
  assign off_o[SL_HST] = OFF_W'(512);
  assign off_o[SL_HCP] = OFF_W'(520);

  assign act_o[SL_X87] = rfbm_i[0];
  assign act_o[SL_CSR] = rfbm_i[1] | (rfbm_i[2] & ~compact_i);
  assign act_o[SL_SSE] = rfbm_i[1];
  assign act_o[SL_HST] = 1'b1;
  assign act_o[SL_HCP] = compact_i;

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    localparam int B = ext_bit(k);
    if (k < NEXT - 1) begin : g_acc
      // packed chain: only selected areas consume space
      assign acc[k+1] = acc[k] + (rfbm_i[B] ? OFF_W'(ext_size(k)) : OFF_W'(0));
    end
    assign off_o[SL_EXT+k] = compact_i ? acc[k] : OFF_W'(ext_std_off(k));
    assign act_o[SL_EXT+k] = rfbm_i[B];
  end
endmodule

// File: rtl/xsave_pick.sv
module xsave_pick #(
  parameter int N = 9
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] onehot_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign onehot_o[i] = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/xsave_hdr.sv
module xsave_hdr #(
  parameter int FEAT_W = 8,
  parameter int HDR_W  = 64
) (
  input  logic [FEAT_W-1:0] rfbm_i,
  input  logic [FEAT_W-1:0] use_i,
  input  logic [HDR_W-1:0]  old_i,
  input  logic              compact_i,
  output logic [HDR_W-1:0]  state_o,
  output logic [HDR_W-1:0]  comp_o
);
  logic [HDR_W-1:0] rfbm_x, use_x;
  assign rfbm_x  = HDR_W'(rfbm_i);
  assign use_x   = HDR_W'(use_i);
  assign state_o = compact_i ? use_x : ((old_i & ~rfbm_x) | use_x);
  assign comp_o  = rfbm_x | (HDR_W'(1) << (HDR_W - 1));
endmodule

// File: rtl/xsave_seq.sv
module xsave_seq
  import xsave_seq_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int FEAT_W   = 8,
  parameter int HDR_W    = 64,
  parameter int ALIGN_LG = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [FEAT_W-1:0] feat_en_i,
  input  logic [FEAT_W-1:0] feat_req_i,
  input  logic [FEAT_W-1:0] in_use_i,
  input  logic [1:0]        mode_i,
  input  logic [HDR_W-1:0]  old_state_i,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [1:0]        desc_kind_o,
  output logic [2:0]        desc_comp_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic              desc_write_o,
  output logic [HDR_W-1:0]  desc_data_o,
  output logic              done_o,
  output logic              fault_o
);
  logic [NSLOT-1:0]  pend_q, act, pick_oh, pend_nx;
  logic [ADDR_W-1:0] base_q;
  logic [FEAT_W-1:0] rfbm_q, use_q, rfbm_in, rfbm_sel;
  logic [1:0]        mode_q;
  logic [HDR_W-1:0]  old_q, hdr_state, hdr_comp;
  logic              done_q, fault_q, busy, cmp_q, skip_q, cmp_sel, start_ok, fire;
  logic [NSLOT-1:0][OFF_W-1:0] off;
  logic [OFF_W-1:0]  off_sel;
  logic [1:0]        kind_sel;
  logic [2:0]        comp_sel;

  assign rfbm_in  = feat_en_i & feat_req_i;
  assign cmp_q    = (mode_q == MODE_CMP);
  assign skip_q   = (mode_q == MODE_OPT) | cmp_q;
  // idle: layout evaluates the incoming request to seed the slot set
  assign rfbm_sel = busy ? rfbm_q : rfbm_in;
  assign cmp_sel  = busy ? cmp_q : (mode_i == MODE_CMP);
  assign start_ok = start_i & ~busy;
  assign fire     = busy & desc_ready_i;
  assign pend_nx  = pend_q & ~pick_oh;

  xsave_layout #(.FEAT_W(FEAT_W)) u_layout (
    .rfbm_i   (rfbm_sel),
    .compact_i(cmp_sel),
    .off_o    (off),
    .act_o    (act)
  );

  xsave_pick #(.N(NSLOT)) u_pick (
    .req_i   (pend_q),
    .onehot_o(pick_oh),
    .any_o   (busy)
  );

  xsave_hdr #(.FEAT_W(FEAT_W), .HDR_W(HDR_W)) u_hdr (
    .rfbm_i   (rfbm_q),
    .use_i    (use_q),
    .old_i    (old_q),
    .compact_i(cmp_q),
    .state_o  (hdr_state),
    .comp_o   (hdr_comp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      base_q  <= '0;
      rfbm_q  <= '0;
      use_q   <= '0;
      mode_q  <= MODE_STD;
      old_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (start_ok) begin
        if (|base_i[ALIGN_LG-1:0]) begin
          fault_q <= 1'b1;
        end else begin
          pend_q <= act;
          base_q <= base_i;
          rfbm_q <= rfbm_in;
          use_q  <= rfbm_in & in_use_i;
          mode_q <= mode_i;
          old_q  <= old_state_i;
        end
      end else if (fire) begin
        pend_q <= pend_nx;
        if (pend_nx == '0) done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    off_sel  = '0;
    kind_sel = KIND_COMP;
    comp_sel = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (pick_oh[s]) begin
        off_sel  = off[s];
        kind_sel = slot_kind(s);
        comp_sel = slot_comp(s);
      end
    end
  end

  always_comb begin
    desc_data_o = '0;
    if (pick_oh[SL_HST]) desc_data_o = hdr_state;
    if (pick_oh[SL_HCP]) desc_data_o = hdr_comp;
  end

  assign desc_valid_o = busy;
  assign desc_kind_o  = kind_sel;
  assign desc_comp_o  = comp_sel;
  assign desc_addr_o  = base_q + ADDR_W'(off_sel);
  assign desc_write_o = (kind_sel != KIND_COMP) | ~skip_q | use_q[comp_sel];
  assign done_o       = done_q;
  assign fault_o      = fault_q;
endmodule

// File: rtl/xsave_seq_chk.sv
module xsave_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int HDR_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              desc_valid_o,
  input logic              desc_ready_i,
  input logic [1:0]        desc_kind_o,
  input logic [ADDR_W-1:0] desc_addr_o,
  input logic [HDR_W-1:0]  desc_data_o,
  input logic              done_o,
  input logic              fault_o
);
  a_r10_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_addr_o) && $stable(desc_kind_o));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !desc_valid_o);

  a_r2_fault_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !desc_valid_o && (|base_i[5:0]) |=> fault_o && !desc_valid_o);

  a_r2_fault_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !desc_valid_o && !done_o);

  a_r2_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_addr_o[2:0] == 3'd0);

  a_r9_comp_word_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_kind_o == 2'd2 && desc_addr_o[5:0] == 6'd8 |-> desc_data_o[HDR_W-1]);
endmodule

bind xsave_seq xsave_seq_chk #(.ADDR_W(ADDR_W), .HDR_W(HDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .base_i      (base_i),
  .desc_valid_o(desc_valid_o),
  .desc_ready_i(desc_ready_i),
  .desc_kind_o (desc_kind_o),
  .desc_addr_o (desc_addr_o),
  .desc_data_o (desc_data_o),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/xsave_seq_bench.sv
module xsave_seq_bench;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] base_i = '0;
  logic [7:0]  feat_en_i = '0, feat_req_i = '0, in_use_i = '0;
  logic [1:0]  mode_i = '0;
  logic [63:0] old_state_i = '0;
  logic        desc_ready_i = 1'b0;
  logic        desc_valid_o, desc_write_o, done_o, fault_o;
  logic [1:0]  desc_kind_o;
  logic [2:0]  desc_comp_o;
  logic [63:0] desc_addr_o, desc_data_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0]  e_kind[16], g_kind[16];
  logic [2:0]  e_comp[16], g_comp[16];
  logic [63:0] e_addr[16], g_addr[16], e_data[16], g_data[16];
  logic        e_wr[16], g_wr[16];
  int n_exp, n_got;

  xsave_seq u_xsave_seq (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [2:0] c, input logic [63:0] a,
                      input logic w, input logic [63:0] d);
    e_kind[n_exp] = k; e_comp[n_exp] = c; e_addr[n_exp] = a;
    e_wr[n_exp] = w; e_data[n_exp] = d;
    n_exp++;
  endtask

  task automatic build_exp(input logic [7:0] en, input logic [7:0] rq, input logic [7:0] iu,
                           input logic [1:0] md, input logic [63:0] old, input logic [63:0] base);
    logic [7:0] rf, us;
    bit cmp, opt;
    int off;
    int cbit[4] = '{2, 5, 6, 7};
    int csz[4]  = '{256, 64, 512, 1024};
    int cstd[4] = '{576, 1088, 1152, 1664};
    rf = en & rq; us = rf & iu;
    cmp = (md == 2'd2); opt = (md == 2'd1) || cmp;
    n_exp = 0;
    if (rf[0]) push(2'd0, 3'd0, base, opt ? us[0] : 1'b1, 64'd0);
    if (rf[1] || (rf[2] && !cmp)) push(2'd1, 3'd0, base + 64'd24, 1'b1, 64'd0);
    if (rf[1]) push(2'd0, 3'd1, base + 64'd160, opt ? us[1] : 1'b1, 64'd0);
    off = 576;
    for (int k = 0; k < 4; k++) begin
      if (rf[cbit[k]]) begin
        push(2'd0, 3'(cbit[k]), base + 64'(cmp ? off : cstd[k]), opt ? us[cbit[k]] : 1'b1, 64'd0);
        off += csz[k];
      end
    end
    push(2'd2, 3'd0, base + 64'd512, 1'b1, cmp ? {56'd0, us} : ((old & ~{56'd0, rf}) | {56'd0, us}));
    if (cmp) push(2'd2, 3'd0, base + 64'd520, 1'b1, {1'b1, 55'd0, rf});
  endtask

  task automatic run_op(input string tag, input logic [7:0] en, input logic [7:0] rq,
                        input logic [7:0] iu, input logic [1:0] md, input logic [63:0] old,
                        input logic [63:0] base, input bit stall, input bit restart);
    int cyc;
    bit rdy, seen_fault;
    build_exp(en, rq, iu, md, old, base);
    @(negedge clk_i);
    feat_en_i = en; feat_req_i = rq; in_use_i = iu; mode_i = md;
    old_state_i = old; base_i = base; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(desc_valid_o == 1'b1, {tag, " R10 valid after start"}, 64'(desc_valid_o), 64'd1);
    n_got = 0; cyc = 0; seen_fault = 0;
    while (!done_o && cyc < 200) begin
      if (fault_o) seen_fault = 1;
      rdy = stall ? (cyc % 3 != 1) : 1'b1;
      desc_ready_i = rdy;
      start_i = restart && (cyc == 2);
      if (restart && cyc == 2) begin
        base_i = 64'h3; mode_i = 2'd2; feat_req_i = 8'hFF; in_use_i = 8'h00; old_state_i = '1;
      end
      if (desc_valid_o && rdy && n_got < 16) begin
        g_kind[n_got] = desc_kind_o; g_comp[n_got] = desc_comp_o; g_addr[n_got] = desc_addr_o;
        g_wr[n_got] = desc_write_o; g_data[n_got] = desc_data_o;
        n_got++;
      end
      @(negedge clk_i);
      cyc++;
    end
    desc_ready_i = 1'b0; start_i = 1'b0;
    check(done_o == 1'b1, {tag, " R11 done reached"}, 64'(done_o), 64'd1);
    check(!seen_fault, {tag, " R11 no fault while busy"}, 64'(seen_fault), 64'd0);
    check(n_got == n_exp, {tag, " R3 descriptor count"}, 64'(n_got), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check({g_kind[i], g_comp[i], g_wr[i]} == {e_kind[i], e_comp[i], e_wr[i]},
            {tag, " R3/R6 kind,comp,write"}, 64'({g_kind[i], g_comp[i], g_wr[i]}),
            64'({e_kind[i], e_comp[i], e_wr[i]}));
      check(g_addr[i] == e_addr[i], {tag, " address"}, g_addr[i], e_addr[i]);
      check(g_data[i] == e_data[i], {tag, " header data"}, g_data[i], e_data[i]);
    end
    @(negedge clk_i);
    check(!done_o && !desc_valid_o, {tag, " R11 done is one pulse"}, 64'({done_o, desc_valid_o}), 64'd0);
  endtask

  task automatic t_reset();
    check(!desc_valid_o && !done_o && !fault_o, "R12 reset outputs",
          64'({desc_valid_o, done_o, fault_o}), 64'd0);
  endtask

  task automatic t_std_full();
    run_op("R4 R6 R7 R8 standard", 8'hE7, 8'hFF, 8'h25, 2'd0,
           64'hFFFF_0000_0000_0018, 64'h0000_0001_0000_0040, 1'b0, 1'b0);
  endtask

  task automatic t_opt_stall();
    run_op("R6 R8 R10 R11 optimized", 8'hE7, 8'h07, 8'h42, 2'd1,
           64'h0000_0000_0000_0080, 64'h0000_0000_0000_1000, 1'b1, 1'b1);
  endtask

  task automatic t_cmp_full();
    run_op("R5 R7 R9 compacted", 8'hE7, 8'hE5, 8'hE0, 2'd2,
           64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_2000, 1'b0, 1'b0);
  endtask

  task automatic t_cmp_sparse();
    run_op("R5 R9 compacted sparse", 8'hFF, 8'hA0, 8'hFF, 2'd2,
           64'h0, 64'h0000_0000_0003_0000, 1'b1, 1'b0);
  endtask

  task automatic t_req_mask();
    run_op("R1 R7 mask and", 8'h07, 8'hE5, 8'h00, 2'd0,
           64'h0, 64'h0000_0000_0000_4000, 1'b0, 1'b0);
  endtask

  task automatic t_empty();
    run_op("R1 R8 empty request", 8'hE7, 8'h00, 8'hFF, 2'd1,
           64'h0000_0000_0000_0123, 64'h0000_0000_0000_5000, 1'b0, 1'b0);
  endtask

  task automatic t_mode3();
    run_op("R4 R6 mode3 as standard", 8'hE7, 8'h03, 8'h00, 2'd3,
           64'h0, 64'h0000_0000_0000_6000, 1'b0, 1'b0);
  endtask

  task automatic t_fault();
    @(negedge clk_i);
    base_i = 64'h0000_0000_1000_0010; feat_en_i = 8'hE7; feat_req_i = 8'hFF; mode_i = 2'd0;
    desc_ready_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(fault_o && !desc_valid_o, "R2 fault next cycle", 64'({fault_o, desc_valid_o}), 64'b10);
    @(negedge clk_i);
    check(!fault_o && !desc_valid_o && !done_o, "R2 fault pulse only",
          64'({fault_o, desc_valid_o, done_o}), 64'd0);
    desc_ready_i = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 2);
    t_reset();
    rst_ni = 1'b1;
    t_std_full();
    t_opt_stall();
    t_cmp_full();
    t_cmp_sparse();
    t_req_mask();
    t_empty();
    t_mode3();
    t_fault();
    t_std_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule